// File: doc/BRIEF.md
# Alternate Pattern Switch Controller

This controller decides which of two equal-length user patterns is sent out by a pattern generator. In alternate mode the pattern memory is split into two halves, and each half holds one pattern. The playback logic reports the last bit of each pattern pass with a one-cycle strobe. The controller registers a half-select output, and that output only changes on that strobe. Because of this, a changeover never cuts a pattern short.

A switch can be asked for in three ways: by a software request, by a rising edge on an auxiliary input, or by the level of that auxiliary input. Software requests and edge requests are held as pending until the next pattern end. Two control styles are available. In toggle style the controller moves to the other half and stays there. In one-shot style it visits the other half for a single pattern pass and then returns. When alternate mode is off, the auxiliary input can instead blank the data output. The blanking takes effect on the next clock and does not disturb the pattern position.

The auxiliary input is asynchronous. It passes through a synchronizer chain of flops before any edge or level is taken from it.

Top module: `alt_pattern_switch`

## Requirements
- R1: After reset, `half_sel` is 0 and `data_kill` is 0.
- R2: A request (`sw_req` high for a cycle) while alternate mode is on is held as pending. `half_sel` does not change until the next cycle with `pat_end` high, and then changes on that clock edge.
- R3: With `oneshot` = 0 (toggle style), a pending request inverts `half_sel` at the pattern end. The new half is kept at every later pattern end that has no new request.
- R4: With `oneshot` = 1, a pending request moves `half_sel` to the other half at one pattern end and back at the following one. Requests made during that single-pass visit are discarded when it ends.
- R5: With `aux_mode` = 0 (edge trigger), each rising edge of the synchronized `aux_in` acts as one request. A level that stays high does not request again.
- R6: With `aux_mode` = 1 (level select), at every pattern end `half_sel` takes the synchronized level of `aux_in`, and `sw_req` has no effect.
- R7: With `alt_en` = 0 and `aux_mode` = 2 (blanking), `data_kill` follows `aux_in` three clock edges after the input changes: two synchronizer edges and one output register edge.
- R8: While `alt_en` = 0, `half_sel` is 0 and pending requests are dropped. Requests and aux edges made while it is 0 are not acted on after it returns to 1.
- R9: A request in the same cycle as `pat_end` takes effect at that same pattern end.
- R10: With `alt_en` = 1 and `aux_mode` = 2, the auxiliary input is ignored: `data_kill` stays 0 and `half_sel` does not change. `aux_mode` = 3 also ignores the auxiliary input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_en | input | 1 | Alternate mode enable (memory split in two halves) |
| aux_mode | input | 2 | Aux input use: 0 edge trigger, 1 level select, 2 blanking, 3 ignored |
| oneshot | input | 1 | 1 = single-pass visit, 0 = toggle and stay |
| aux_in | input | 1 | Asynchronous auxiliary input |
| sw_req | input | 1 | Software switch request, one cycle per request |
| pat_end | input | 1 | Strobe on the last bit of each pattern pass |
| half_sel | output | 1 | Active memory half (0 or 1) |
| data_kill | output | 1 | Forces the data output to zero when high |

## Verification
If the pending flag, the base half or the one-shot flag holds a wrong value, it shows as a flip of `half_sel` at a pattern end where none is due, or as a missing flip. Either way the error appears within one pattern pass of the request. A fault in the synchronizer chain or the edge detector shows up as a blanking edge that arrives a cycle early or late. It can also show up as a held aux level that triggers a second switch. The directed cases therefore sample `half_sel` just before and just after each strobe, and sample `data_kill` at the exact edge where it must move.

// File: rtl/altpat_pkg.sv
package altpat_pkg;

    typedef enum logic [1:0] {
        AUX_EDGE  = 2'd0,
        AUX_LEVEL = 2'd1,
        AUX_BLANK = 2'd2,
        AUX_NONE  = 2'd3
    } aux_use_e;

    typedef struct packed {
        logic base;   // half chosen by toggle or level control
        logic visit;  // one-shot visit to the other half in progress
        logic pend;   // request waiting for the next pattern end
    } sel_state_t;

endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_in,
    output logic aux_lvl,
    output logic aux_rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], aux_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign aux_lvl  = chain_q[SYNC_STAGES-1];
    assign aux_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R5: one edge gives a single-cycle request
    a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rise |=> !aux_rise);

endmodule

// File: rtl/switch_core.sv
module switch_core
    import altpat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alt_en,
    input  logic level_mode,
    input  logic level_val,
    input  logic oneshot,
    input  logic req,
    input  logic pat_end,
    output logic half
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!alt_en) begin
            st_d = '0;
        end else if (level_mode) begin
            st_d.pend = 1'b0;
            if (pat_end) begin
                st_d.base  = level_val;
                st_d.visit = 1'b0;
            end
        end else if (pat_end) begin
            if (st_q.visit) begin
                st_d.visit = 1'b0;
                st_d.pend  = 1'b0;
            end else if (st_q.pend || req) begin
                st_d.pend = 1'b0;
                if (oneshot) st_d.visit = 1'b1;
                else         st_d.base  = ~st_q.base;
            end
        end else if (req) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half = st_q.base ^ st_q.visit;

    // R2: the selected half only moves at a pattern end
    a_r2_hold_between_ends: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en && !pat_end |=> $stable(half));

    // R2: a pattern end consumes the pending request
    a_r2_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        pat_end |=> !st_q.pend);

    // R4: a one-shot visit lasts one pattern pass
    a_r4_visit_ends: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.visit && pat_end |=> !st_q.visit);

    // R8: alternate mode off forces half 0 and drops requests
    a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |=> (half == 1'b0) && !st_q.pend);

endmodule

// File: rtl/blank_ctrl.sv
module blank_ctrl
    import altpat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     alt_en,
    input  aux_use_e aux_use,
    input  logic     aux_lvl,
    output logic     kill
);
    logic kill_d, kill_q;

    always_comb begin
        kill_d = (aux_use == AUX_BLANK) && !alt_en && aux_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) kill_q <= 1'b0;
        else        kill_q <= kill_d;
    end

    assign kill = kill_q;

    // R10: no blanking while alternate mode is on
    a_r10_no_kill_in_alt: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en |=> !kill);

endmodule

// File: rtl/alt_pattern_switch.sv
module alt_pattern_switch
    import altpat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alt_en,
    input  logic [1:0] aux_mode,
    input  logic       oneshot,
    input  logic       aux_in,
    input  logic       sw_req,
    input  logic       pat_end,
    output logic       half_sel,
    output logic       data_kill
);
    aux_use_e aux_use;
    logic     aux_lvl, aux_rise, req, level_mode;

    assign aux_use    = aux_use_e'(aux_mode);
    assign level_mode = (aux_use == AUX_LEVEL);
    assign req        = sw_req || (aux_use == AUX_EDGE && aux_rise);

    aux_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_in   (aux_in),
        .aux_lvl  (aux_lvl),
        .aux_rise (aux_rise)
    );

    switch_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_en     (alt_en),
        .level_mode (level_mode),
        .level_val  (aux_lvl),
        .oneshot    (oneshot),
        .req        (req),
        .pat_end    (pat_end),
        .half       (half_sel)
    );

    blank_ctrl i_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .alt_en  (alt_en),
        .aux_use (aux_use),
        .aux_lvl (aux_lvl),
        .kill    (data_kill)
    );

endmodule

// File: tb/test_alt_pattern_switch.sv
`timescale 1ns/1ps
module test_alt_pattern_switch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_en = 1'b0;
    logic [1:0] aux_mode = 2'd3;
    logic       oneshot = 1'b0;
    logic       aux_in = 1'b0;
    logic       sw_req = 1'b0;
    logic       pat_end = 1'b0;
    logic       half_sel, data_kill;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    alt_pattern_switch i_alt_pattern_switch (
        .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .aux_mode(aux_mode),
        .oneshot(oneshot), .aux_in(aux_in), .sw_req(sw_req), .pat_end(pat_end),
        .half_sel(half_sel), .data_kill(data_kill)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic boundary();
        pat_end = 1'b1; tick(); pat_end = 1'b0;
    endtask

    task automatic request();
        sw_req = 1'b1; tick(); sw_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 half", half_sel, 1'b0);
        check("R1 kill", data_kill, 1'b0);
    endtask

    task automatic t_toggle();
        alt_en = 1'b1; aux_mode = 2'd3; oneshot = 1'b0; tick();
        request(); tick(3);
        check("R2 deferred", half_sel, 1'b0);
        boundary();
        check("R3 flip", half_sel, 1'b1);
        boundary();
        check("R3 stays", half_sel, 1'b1);
        boundary();
        check("R3 stays again", half_sel, 1'b1);
        request(); boundary();
        check("R3 flip back", half_sel, 1'b0);
    endtask

    task automatic t_oneshot();
        oneshot = 1'b1;
        request(); boundary();
        check("R4 visit", half_sel, 1'b1);
        boundary();
        check("R4 return", half_sel, 1'b0);
        request(); boundary();
        check("R4 visit 2", half_sel, 1'b1);
        request(); boundary();
        check("R4 return 2", half_sel, 1'b0);
        boundary();
        check("R4 request discarded", half_sel, 1'b0);
        oneshot = 1'b0;
    endtask

    task automatic t_coincide();
        sw_req = 1'b1; pat_end = 1'b1; tick(); sw_req = 1'b0; pat_end = 1'b0;
        check("R9 same end", half_sel, 1'b1);
        boundary();
        check("R9 nothing pending", half_sel, 1'b1);
        request(); boundary();
        check("R9 restore", half_sel, 1'b0);
    endtask

    task automatic t_edge();
        aux_mode = 2'd0;
        aux_in = 1'b1; tick(4); aux_in = 1'b0; tick(2);
        check("R5 deferred", half_sel, 1'b0);
        boundary();
        check("R5 edge switch", half_sel, 1'b1);
        boundary();
        check("R5 one edge one switch", half_sel, 1'b1);
        aux_in = 1'b1; tick(4);
        boundary();
        check("R5 second edge", half_sel, 1'b0);
        boundary();
        check("R5 held level no retrigger", half_sel, 1'b0);
        aux_in = 1'b0; tick(3);
    endtask

    task automatic t_level();
        aux_mode = 2'd1;
        aux_in = 1'b1; tick(3);
        check("R6 waits for end", half_sel, 1'b0);
        boundary();
        check("R6 level high", half_sel, 1'b1);
        request(); boundary();
        check("R6 sw ignored", half_sel, 1'b1);
        aux_in = 1'b0; tick(3); boundary();
        check("R6 level low", half_sel, 1'b0);
    endtask

    task automatic t_alt_off();
        aux_mode = 2'd0;
        request(); boundary();
        check("R8 setup", half_sel, 1'b1);
        alt_en = 1'b0; tick();
        check("R8 forced half 0", half_sel, 1'b0);
        request();
        aux_in = 1'b1; tick(4); aux_in = 1'b0; tick(3);
        check("R8 no kill in edge mode", data_kill, 1'b0);
        alt_en = 1'b1; tick(); boundary();
        check("R8 requests dropped", half_sel, 1'b0);
    endtask

    task automatic t_blank();
        alt_en = 1'b0; aux_mode = 2'd2; tick();
        check("R7 idle", data_kill, 1'b0);
        aux_in = 1'b1; tick(2);
        check("R7 not yet", data_kill, 1'b0);
        tick();
        check("R7 blanked", data_kill, 1'b1);
        check("R7 half 0", half_sel, 1'b0);
        aux_in = 1'b0; tick(2);
        check("R7 still blanked", data_kill, 1'b1);
        tick();
        check("R7 released", data_kill, 1'b0);
    endtask

    task automatic t_blank_alt();
        alt_en = 1'b1; aux_mode = 2'd2; tick();
        aux_in = 1'b1; tick(4);
        check("R10 no kill", data_kill, 1'b0);
        boundary();
        check("R10 half kept", half_sel, 1'b0);
        aux_in = 1'b0; aux_mode = 2'd3; tick(3);
        aux_in = 1'b1; tick(4); aux_in = 1'b0; tick(3); boundary();
        check("R10 mode 3 ignores aux", half_sel, 1'b0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_toggle();
        t_oneshot();
        t_coincide();
        t_edge();
        t_level();
        t_alt_off();
        t_blank();
        t_blank_alt();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule